// File: doc/BRIEF.md
# Zone Block-Map Allocator with Wear Levelling

This block holds the logical-to-physical map of a single flash zone of 1024 physical erase blocks. Every physical block sits in exactly one of three parts: mapped (serving a logical index), spare (a circular queue kept in release order), or retired (unusable). A controller first streams in the list of blocks known to be unusable. The allocator then picks how many logical indices it can expose and fills the map and the spare queue by walking the zone once.

In service the block answers three commands. A lookup returns the physical block behind a logical index. A write-allocate hands out the spare block released longest ago as the new home of a logical index and queues the old block for reuse once it has been erased. A retire moves a failing mapped block into the retired part and maps a spare block in its place. The allocator only names blocks; copying pages, erasing and flash traffic belong to the caller.

Top module: `lut_zone_alloc`

## Requirements
- R1: After reset `ready_o` and `fail_o` are low and no response is pending. Any command taken while `ready_o` is low is answered with status 3 (not ready) and leaves the map unchanged.
- R2: An init begins with a one-cycle `init_start_i`. Each cycle with `init_bad_valid_i` marks `init_bad_blk_i` unusable, and the cycle with `init_done_i` closes the list. A block listed more than once counts once, so `bad_count_o` equals the number of distinct unusable blocks.
- R3: `init_size_i` asks for 1000 logical blocks (0), 900 (1) or 500 (2 or 3). The allocator takes the first size, from the one asked for downwards, for which size + unusable + 1 <= 1024 holds, and shows it on `used_size_o`. If no size fits, `fail_o` goes high and `ready_o` stays low.
- R4: After the init, logical index i maps to the i-th usable block in ascending physical order. The usable blocks left over enter the spare queue in ascending order.
- R5: Lookup (op 0, and op 3 alike) of an index in range returns status 0 with the mapped block on both `rsp_old_o` and `rsp_phys_o`.
- R6: Write-allocate (op 1) returns status 0, the old block on `rsp_old_o` and the head of the spare queue on `rsp_phys_o`. It then maps the index to that block and appends the old block to the tail of the queue.
- R7: Retire (op 2) returns status 0, the failing block on `rsp_old_o` and the spare queue head on `rsp_phys_o`. The failing block is counted in `bad_count_o` and never comes back to the queue.
- R8: Any command whose index is at or above `used_size_o` returns status 1 (range) and changes nothing.
- R9: A write-allocate or retire made while the spare queue is empty returns status 2 (no spare) and leaves the map unchanged.
- R10: Each command cycle yields exactly one response, with `rsp_valid_o` high for one cycle, one clock after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_start_i | input | 1 | Begin a new init, clearing all state |
| init_size_i | input | 2 | Requested logical size selector |
| init_bad_valid_i | input | 1 | An unusable block number is presented |
| init_bad_blk_i | input | 10 | Unusable physical block number |
| init_done_i | input | 1 | Unusable list complete |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0/3 lookup, 1 write-allocate, 2 retire |
| cmd_lidx_i | input | 10 | Logical block index |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_status_o | output | 2 | 0 ok, 1 range, 2 no spare, 3 not ready |
| rsp_old_o | output | 10 | Block currently mapped (old block) |
| rsp_phys_o | output | 10 | Block mapped after the command |
| ready_o | output | 1 | Map built and serving commands |
| fail_o | output | 1 | No logical size fits the unusable count |
| used_size_o | output | 11 | Logical blocks exposed |
| bad_count_o | output | 11 | Blocks in the retired part |

## Verification
Every command response is due one clock after the command cycle. The bench drives a command on a falling edge, withdraws it on the next falling edge and reads the response there, then confirms on the following falling edge that the strobe has dropped. After `init_done_i` the map is built in one pass of 1024 cycles. The bench polls `ready_o` and `fail_o` on falling edges and checks the size and count only once one of them is up, and it sends one command inside the build window to see the not-ready answer.

// File: rtl/lut_alloc_pkg.sv
package lut_alloc_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_WRITE  = 2'd1,
    OP_RETIRE = 2'd2,
    OP_PEEK   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RS_OK        = 2'd0,
    RS_RANGE     = 2'd1,
    RS_NO_FREE   = 2'd2,
    RS_NOT_READY = 2'd3
  } status_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LOAD, PH_BUILD, PH_READY, PH_FAIL
  } phase_e;
endpackage

// File: rtl/lut_free_fifo.sv
module lut_free_fifo #(
  parameter int DEPTH = 1024,
  parameter int W     = 10,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  push_data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem_q[wp_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
      if (pop_i)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o  = mem_q[rp_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/lut_map_ram.sv
module lut_map_ram #(
  parameter int DEPTH = 1024,
  parameter int W     = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lut_bad_set.sv
module lut_bad_set #(
  parameter int ZONE_BLKS = 1024,
  localparam int BW       = $clog2(ZONE_BLKS),
  localparam int CW       = $clog2(ZONE_BLKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          set_i,
  input  logic [BW-1:0] set_idx_i,
  input  logic [BW-1:0] query_idx_i,
  output logic          query_bad_o,
  output logic [CW-1:0] count_o
);
  logic [ZONE_BLKS-1:0] bits_q;
  logic [CW-1:0]        cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else if (set_i && !bits_q[set_idx_i]) begin
      // repeated entries count once
      bits_q[set_idx_i] <= 1'b1;
      cnt_q             <= cnt_q + CW'(1);
    end
  end

  assign query_bad_o = bits_q[query_idx_i];
  assign count_o     = cnt_q;
endmodule

// File: rtl/lut_zone_alloc.sv
module lut_zone_alloc
  import lut_alloc_pkg::*;
#(
  parameter int ZONE_BLKS   = 1024,
  parameter int USED_FULL   = 1000,
  parameter int USED_NINETY = 900,
  parameter int USED_HALF   = 500,
  localparam int BW         = $clog2(ZONE_BLKS),
  localparam int CW         = $clog2(ZONE_BLKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_start_i,
  input  logic [1:0]    init_size_i,
  input  logic          init_bad_valid_i,
  input  logic [BW-1:0] init_bad_blk_i,
  input  logic          init_done_i,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [BW-1:0] cmd_lidx_i,
  output logic          rsp_valid_o,
  output logic [1:0]    rsp_status_o,
  output logic [BW-1:0] rsp_old_o,
  output logic [BW-1:0] rsp_phys_o,
  output logic          ready_o,
  output logic          fail_o,
  output logic [CW-1:0] used_size_o,
  output logic [CW-1:0] bad_count_o
);
  phase_e        phase_q;
  logic [1:0]    req_q;
  logic [CW-1:0] used_q, lcnt_q;
  logic [BW-1:0] scan_q;

  logic [CW-1:0] bad_cnt, free_cnt;
  logic          scan_bad;
  logic [BW-1:0] free_head, map_rdata;

  // size choice with fallback
  logic [CW-1:0] cand [3];
  logic [CW-1:0] pick;
  logic          pick_ok;
  int            start_k;

  assign cand[0] = CW'(USED_FULL);
  assign cand[1] = CW'(USED_NINETY);
  assign cand[2] = CW'(USED_HALF);

  always_comb begin
    start_k = (req_q == 2'd3) ? 2 : int'(req_q);
    pick    = '0;
    pick_ok = 1'b0;
    for (int k = 2; k >= 0; k--) begin
      if (k >= start_k && (int'(cand[k]) + int'(bad_cnt) + 1) <= ZONE_BLKS) begin
        pick    = cand[k];
        pick_ok = 1'b1;
      end
    end
  end

  // build pass
  logic in_build, build_map_we, build_push;
  assign in_build     = (phase_q == PH_BUILD);
  assign build_map_we = in_build && !scan_bad && (lcnt_q < used_q);
  assign build_push   = in_build && !scan_bad && (lcnt_q >= used_q);

  // command decode
  op_e  op;
  logic is_ready, is_wr, is_ret, in_range, free_empty, act_ok;
  assign op         = op_e'(cmd_op_i);
  assign is_ready   = (phase_q == PH_READY);
  assign is_wr      = (op == OP_WRITE);
  assign is_ret     = (op == OP_RETIRE);
  assign in_range   = CW'(cmd_lidx_i) < used_q;
  assign free_empty = (free_cnt == '0);
  assign act_ok     = is_ready && cmd_valid_i && (is_wr || is_ret) && in_range && !free_empty;

  logic          map_we, fifo_push, bad_set;
  logic [BW-1:0] map_waddr, map_wdata, push_data, bad_idx;
  assign map_we    = build_map_we || act_ok;
  assign map_waddr = in_build ? lcnt_q[BW-1:0] : cmd_lidx_i;
  assign map_wdata = in_build ? scan_q : free_head;
  assign fifo_push = build_push || (act_ok && is_wr);
  assign push_data = in_build ? scan_q : map_rdata;
  assign bad_set   = ((phase_q == PH_LOAD) && init_bad_valid_i && !init_done_i) ||
                     (act_ok && is_ret);
  assign bad_idx   = (phase_q == PH_LOAD) ? init_bad_blk_i : map_rdata;

  lut_map_ram #(.DEPTH(ZONE_BLKS), .W(BW)) u_map (
    .clk_i   (clk_i),
    .we_i    (map_we),
    .waddr_i (map_waddr),
    .wdata_i (map_wdata),
    .raddr_i (cmd_lidx_i),
    .rdata_o (map_rdata)
  );

  lut_free_fifo #(.DEPTH(ZONE_BLKS), .W(BW)) u_free (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (init_start_i),
    .push_i      (fifo_push),
    .push_data_i (push_data),
    .pop_i       (act_ok),
    .head_o      (free_head),
    .count_o     (free_cnt)
  );

  lut_bad_set #(.ZONE_BLKS(ZONE_BLKS)) u_bad (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (init_start_i),
    .set_i       (bad_set),
    .set_idx_i   (bad_idx),
    .query_idx_i (scan_q),
    .query_bad_o (scan_bad),
    .count_o     (bad_cnt)
  );

  // phase sequencing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      req_q   <= '0;
      used_q  <= '0;
      lcnt_q  <= '0;
      scan_q  <= '0;
    end else if (init_start_i) begin
      phase_q <= PH_LOAD;
      req_q   <= init_size_i;
      used_q  <= '0;
      lcnt_q  <= '0;
      scan_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_LOAD: begin
          if (init_done_i) begin
            if (pick_ok) begin
              used_q  <= pick;
              phase_q <= PH_BUILD;
            end else begin
              phase_q <= PH_FAIL;
            end
          end
        end
        PH_BUILD: begin
          if (build_map_we) lcnt_q <= lcnt_q + CW'(1);
          scan_q <= scan_q + BW'(1);
          if (scan_q == BW'(ZONE_BLKS - 1)) phase_q <= PH_READY;
        end
        default: ;
      endcase
    end
  end

  // response register
  status_e       st_d;
  logic [BW-1:0] old_d, phys_d;

  always_comb begin
    st_d   = RS_OK;
    old_d  = '0;
    phys_d = '0;
    if (!is_ready) begin
      st_d = RS_NOT_READY;
    end else if (!in_range) begin
      st_d = RS_RANGE;
    end else if (!(is_wr || is_ret)) begin
      old_d  = map_rdata;
      phys_d = map_rdata;
    end else if (free_empty) begin
      st_d = RS_NO_FREE;
    end else begin
      old_d  = map_rdata;
      phys_d = free_head;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_status_o <= '0;
      rsp_old_o    <= '0;
      rsp_phys_o   <= '0;
    end else begin
      rsp_valid_o <= cmd_valid_i;
      if (cmd_valid_i) begin
        rsp_status_o <= st_d;
        rsp_old_o    <= old_d;
        rsp_phys_o   <= phys_d;
      end
    end
  end

  assign ready_o     = is_ready;
  assign fail_o      = (phase_q == PH_FAIL);
  assign used_size_o = used_q;
  assign bad_count_o = bad_cnt;
endmodule

// File: rtl/lut_zone_alloc_chk.sv
module lut_zone_alloc_chk #(
  parameter int ZONE_BLKS = 1024,
  localparam int BW       = $clog2(ZONE_BLKS),
  localparam int CW       = $clog2(ZONE_BLKS + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [1:0]    cmd_op_i,
  input logic [BW-1:0] cmd_lidx_i,
  input logic          rsp_valid_o,
  input logic [1:0]    rsp_status_o,
  input logic [BW-1:0] rsp_old_o,
  input logic [BW-1:0] rsp_phys_o,
  input logic          ready_o,
  input logic          fail_o,
  input logic [CW-1:0] used_size_o,
  input logic [CW-1:0] bad_count_o
);
  // R1
  not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !$past(ready_o) |-> rsp_status_o == 2'd3);

  // R3
  fail_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> !ready_o);

  // R3
  size_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && $past(ready_o) |-> $stable(used_size_o));

  // R2
  part_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (int'(used_size_o) + int'(bad_count_o)) <= ZONE_BLKS);

  // R6
  write_diff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && $past(ready_o) && $past(cmd_valid_i) && $past(cmd_op_i) == 2'd1 &&
    rsp_status_o == 2'd0 |-> rsp_old_o != rsp_phys_o);

  // R7
  retire_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && ready_o && $past(ready_o) && $past(cmd_op_i) == 2'd2 &&
    rsp_status_o == 2'd0 |-> bad_count_o == $past(bad_count_o) + CW'(1));

  // R8
  range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && ready_o && $past(ready_o) && rsp_status_o == 2'd1
    |-> CW'($past(cmd_lidx_i)) >= used_size_o);
endmodule

bind lut_zone_alloc lut_zone_alloc_chk #(.ZONE_BLKS(ZONE_BLKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_op_i     (cmd_op_i),
  .cmd_lidx_i   (cmd_lidx_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_status_o (rsp_status_o),
  .rsp_old_o    (rsp_old_o),
  .rsp_phys_o   (rsp_phys_o),
  .ready_o      (ready_o),
  .fail_o       (fail_o),
  .used_size_o  (used_size_o),
  .bad_count_o  (bad_count_o)
);

// File: tb/lut_zone_alloc_bench.sv
module lut_zone_alloc_bench;
  localparam int ZONE = 1024;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       init_start_i = 1'b0;
  logic [1:0] init_size_i = '0;
  logic       init_bad_valid_i = 1'b0;
  logic [9:0] init_bad_blk_i = '0;
  logic       init_done_i = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [1:0] cmd_op_i = '0;
  logic [9:0] cmd_lidx_i = '0;
  logic       rsp_valid_o;
  logic [1:0] rsp_status_o;
  logic [9:0] rsp_old_o, rsp_phys_o;
  logic       ready_o, fail_o;
  logic [10:0] used_size_o, bad_count_o;

  always #5 clk_i = ~clk_i;

  lut_zone_alloc u_lut_zone_alloc (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model
  int m_map [ZONE];
  bit m_bad [ZONE];
  int m_q [$];
  int m_used = 0;
  int m_nbad = 0;
  bit m_ready = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_size(int sel, int nb);
    int c [3];
    int s;
    c[0] = 1000; c[1] = 900; c[2] = 500;
    s = (sel > 2) ? 2 : sel;
    for (int k = s; k < 3; k++)
      if (c[k] + nb + 1 <= ZONE) return c[k];
    return 0;
  endfunction

  task automatic do_cmd(int op, int lidx);
    int e_st, e_old, e_phys;
    string tag;
    e_old = 0; e_phys = 0;
    if (!m_ready) begin e_st = 3; tag = "R1"; end
    else if (lidx >= m_used) begin e_st = 1; tag = "R8"; end
    else if (op == 0 || op == 3) begin
      e_st = 0; tag = "R5"; e_old = m_map[lidx]; e_phys = m_map[lidx];
    end else if (m_q.size() == 0) begin e_st = 2; tag = "R9"; end
    else begin
      e_st = 0; e_old = m_map[lidx]; e_phys = m_q.pop_front();
      m_map[lidx] = e_phys;
      if (op == 1) begin tag = "R6"; m_q.push_back(e_old); end
      else begin tag = "R7"; m_bad[e_old] = 1; m_nbad++; end
    end
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = 2'(op); cmd_lidx_i = 10'(lidx);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk("R10", int'(rsp_valid_o), 1);
    chk(tag, int'(rsp_status_o), e_st);
    if (e_st == 0) begin
      chk(tag, int'(rsp_old_o), e_old);
      chk(tag, int'(rsp_phys_o), e_phys);
    end
  endtask

  task automatic run_init(int sel, int bl[$]);
    int es, l;
    for (int p = 0; p < ZONE; p++) m_bad[p] = 0;
    m_nbad = 0; m_q.delete(); m_ready = 0;
    foreach (bl[i]) if (!m_bad[bl[i]]) begin m_bad[bl[i]] = 1; m_nbad++; end
    es = exp_size(sel, m_nbad);
    @(negedge clk_i);
    init_start_i = 1'b1; init_size_i = 2'(sel);
    @(negedge clk_i);
    init_start_i = 1'b0;
    foreach (bl[i]) begin
      init_bad_valid_i = 1'b1; init_bad_blk_i = 10'(bl[i]);
      @(negedge clk_i);
    end
    init_bad_valid_i = 1'b0;
    init_done_i = 1'b1;
    @(negedge clk_i);
    init_done_i = 1'b0;
    do_cmd(0, 0);                          // R1: inside build window
    for (int t = 0; t < 2000 && !ready_o && !fail_o; t++) @(negedge clk_i);
    chk("R3", int'(fail_o), (es == 0) ? 1 : 0);
    chk("R3", int'(ready_o), (es == 0) ? 0 : 1);
    chk("R2", int'(bad_count_o), m_nbad);
    if (es != 0) begin
      chk("R3", int'(used_size_o), es);
      m_used = es; l = 0;
      for (int p = 0; p < ZONE; p++)
        if (!m_bad[p]) begin
          if (l < es) begin m_map[l] = p; l++; end
          else m_q.push_back(p);
        end
      m_ready = 1;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int bq [$];
    int r, li;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    chk("R1", int'(ready_o), 0);
    chk("R1", int'(fail_o), 0);
    chk("R1", int'(rsp_valid_o), 0);
    rst_ni = 1'b1;
    do_cmd(1, 5);                          // R1 before any init

    // init A: duplicate entry counted once, full size fits
    bq = {3, 7, 1023, 7};
    run_init(0, bq);
    do_cmd(0, 0); do_cmd(0, 3); do_cmd(3, 999);   // R4 ascending fill
    do_cmd(0, 1000);                       // R8
    do_cmd(1, 1023);                       // R8
    do_cmd(0, 999);
    @(negedge clk_i);
    chk("R10", int'(rsp_valid_o), 0);      // one-cycle strobe

    for (int n = 0; n < 400; n++) begin
      r  = int'($urandom % 10);
      li = int'($urandom % 1024);
      if (r < 4) do_cmd(r % 2 == 0 ? 0 : 3, li);
      else if (r < 9 || m_q.size() < 10) do_cmd(1, li);
      else do_cmd(2, li);
    end
    // drain spare queue with retires
    while (m_q.size() > 0) do_cmd(2, int'($urandom % 1000));
    chk("R7", int'(bad_count_o), m_nbad);
    do_cmd(1, 10);                         // R9
    do_cmd(2, 11);                         // R9
    do_cmd(0, 10);
    do_cmd(0, 11);

    // init B: 90 % with no bad blocks, queue order
    bq = {};
    run_init(1, bq);
    do_cmd(1, 4); do_cmd(1, 4); do_cmd(1, 899); do_cmd(0, 4);
    for (int n = 0; n < 150; n++) do_cmd(1, int'($urandom % 900));

    // init C: 23 bad still fits full size, one spare
    bq = {};
    for (int b = 100; b < 123; b++) bq.push_back(b);
    run_init(0, bq);
    do_cmd(1, 120); do_cmd(1, 120); do_cmd(2, 0); do_cmd(1, 1);

    // init D: 24 bad forces fallback to 900
    bq = {};
    for (int b = 200; b < 224; b++) bq.push_back(b);
    run_init(0, bq);
    do_cmd(0, 899); do_cmd(0, 900);

    // init E: 523 bad, half size with a single spare
    bq = {};
    for (int b = 0; b < 523; b++) bq.push_back(b);
    run_init(2, bq);
    do_cmd(1, 0); do_cmd(1, 0); do_cmd(0, 0); do_cmd(0, 499);

    // init F: 524 bad, nothing fits
    bq = {};
    for (int b = 0; b < 524; b++) bq.push_back(b);
    run_init(3, bq);
    do_cmd(0, 0);                          // R1 after failure

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule